// File: doc/BRIEF.md
# Halt-Gated Instruction Sequencer

This block holds the program counter of a small 8-bit processor that uses 5-bit opcodes, and decides each cycle which instruction address comes next. It advances the address only while a non-zero opcode is present, so the all-zero opcode stops the machine in place. An external start pulse or a trap request feeds the carry input of the address incrementer, which lets a halted machine move on again. The block also performs unconditional jumps, flag-conditional jumps, subroutine call and return through a small hardware return stack, and a register-clear strobe.

A replay instruction re-issues the most recently fetched instruction a given number of times while the address is held. Replayed opcodes are driven onto the issue output, and the clear strobe follows them. Instruction memory, the ALU and the register file are outside the block. It sees the fetched opcode and operand, the ALU flags and the strobes, and drives the address, the issued opcode, the clear strobe and a sticky stack error flag.

Top module: `instr_sequencer`

## Requirements
- R1: After reset the address is 0, the return stack is empty, no replay is pending and the stack error flag is 0.
- R2: While `adv_en` is low, the address, stack, flags latch and replay state do not change, and `reg_clear` stays low.
- R3: A fetched opcode with no control meaning (any non-zero code outside 10010..10111) advances the address by one and is driven unchanged on `issue_op`.
- R4: Opcode 00000 holds the address and drives 0 on `issue_op`. If `start` or `trap` is high in the same step, the address instead advances by one.
- R5: Opcode 10011 loads the address from `operand`.
- R6: Opcode 10010 loads the address from `operand` when the selected flag is set, and otherwise advances by one. The flag is taken from the `alu_flags` value latched at the previous enabled step. `cond_sel` 0 selects bit 0 (zero), 1 selects bit 1 (carry), 2 selects bit 2 (sign) and 3 selects bit 3 (overflow).
- R7: Whenever the issued opcode is 10100 in an enabled step, `reg_clear` is high for that cycle. A fetched 10100 also advances the address by one.
- R8: Opcode 10101 (call) pushes the address plus one and loads the address from `operand`. Opcode 10110 (return) pops the newest entry into the address. The stack is last-in first-out and holds 8 entries.
- R9: A call while 8 entries are held, or a return while the stack is empty, sets `stack_err`, leaves the stack unchanged and advances the address by one. `stack_err` stays set until reset.
- R10: Opcode 10111 with a non-zero `operand` N holds the address and issues 0. Over the next N enabled steps the fetched opcode is ignored, the last fetched opcode other than 10111 is issued, and the address holds until the Nth step, which advances it by one. If N is 0, the address advances by one and 0 is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Step enable; one instruction step per enabled cycle |
| opcode | input | 5 | Opcode fetched at the current address |
| operand | input | 8 | Operand field: jump target, call target or replay count |
| cond_sel | input | 2 | Flag selector for the conditional jump |
| alu_flags | input | 4 | ALU flags {overflow, sign, carry, zero} |
| start | input | 1 | Restart pulse into the incrementer carry |
| trap | input | 1 | Trap request that overrides a halt |
| pc | output | 8 | Current instruction address |
| issue_op | output | 5 | Opcode issued to the datapath this cycle |
| reg_clear | output | 1 | Clear strobe for the general registers |
| stack_err | output | 1 | Sticky return stack overflow/underflow flag |

## Verification
The assertions check on every cycle the behaviour that depends only on the current step. They cover the address holding while disabled, while halted and during a replay, advancing on a wake-up, loading on an unconditional jump, the clear strobe never appearing without an enabled step, and the error flag staying set. The bench's scenarios cover what needs history. These include conditional jumps against flags latched one step earlier, the last-in first-out order of return addresses across nested calls, overflow and underflow leaving the stack contents intact, and which opcode a replay re-issues, including a replayed clear.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPW = 5;
  localparam int NFLAG = 4;

  localparam logic [OPW-1:0] OPC_HALT = 5'b00000;
  localparam logic [OPW-1:0] OPC_CJMP = 5'b10010;
  localparam logic [OPW-1:0] OPC_JMP  = 5'b10011;
  localparam logic [OPW-1:0] OPC_CLR  = 5'b10100;
  localparam logic [OPW-1:0] OPC_CALL = 5'b10101;
  localparam logic [OPW-1:0] OPC_RET  = 5'b10110;
  localparam logic [OPW-1:0] OPC_REP  = 5'b10111;
endpackage

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] sp_q, sp_d;
  logic [AW-1:0] ent_q [DEPTH];
  logic          push_ok, pop_ok;

  assign full    = (sp_q == PW'(DEPTH));
  assign empty   = (sp_q == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty & ~push_req;

  always_comb begin
    sp_d = sp_q;
    if (push_ok)     sp_d = sp_q + PW'(1);
    else if (pop_ok) sp_d = sp_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  // one write-enabled slot per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (sp_q == PW'(g))) ent_q[g] <= push_data;
    end
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == PW'(i + 1)) top_data = ent_q[i];
    end
  end
endmodule

// File: rtl/seq_cond_unit.sv
module seq_cond_unit #(
  parameter int NF = 4,
  localparam int SW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NF-1:0] flags_in,
  input  logic [SW-1:0] sel,
  output logic          taken
);
  logic [NF-1:0] flg_q, flg_d;

  always_comb begin
    flg_d = flg_q;
    if (en) flg_d = flags_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign taken = flg_q[sel];
endmodule

// File: rtl/seq_replay.sv
module seq_replay #(
  parameter int CW  = 8,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_en,
  input  logic           load,
  input  logic [CW-1:0]  count_in,
  input  logic           capture,
  input  logic [OPW-1:0] op_in,
  output logic           busy,
  output logic           last,
  output logic [OPW-1:0] op_out
);
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [OPW-1:0] op_q, op_d;

  assign busy   = (cnt_q != '0);
  assign last   = (cnt_q == CW'(1));
  assign op_out = op_q;

  always_comb begin
    cnt_d = cnt_q;
    op_d  = op_q;
    if (load)                cnt_d = count_in;
    else if (step_en && busy) cnt_d = cnt_q - CW'(1);
    if (capture) op_d = op_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      op_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      op_q  <= op_d;
    end
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic [OPW-1:0]    opcode,
  input  logic [AW-1:0]     operand,
  input  logic [1:0]        cond_sel,
  input  logic [NFLAG-1:0]  alu_flags,
  input  logic              start,
  input  logic              trap,
  output logic [AW-1:0]     pc,
  output logic [OPW-1:0]    issue_op,
  output logic              reg_clear,
  output logic              stack_err
);
  logic [AW-1:0]  pc_q, pc_d, pc_inc, stk_top;
  logic           err_q, err_d;
  logic           carry_in, fetch;
  logic           rep_busy, rep_last;
  logic [OPW-1:0] rep_op;
  logic           stk_full, stk_empty, cond_taken;
  logic           do_call, do_ret, do_rep;

  assign fetch   = adv_en & ~rep_busy;
  assign do_call = fetch & (opcode == OPC_CALL);
  assign do_ret  = fetch & (opcode == OPC_RET);
  assign do_rep  = fetch & (opcode == OPC_REP);

  // incrementer: carry is the OR of the opcode bits, start and trap
  assign carry_in = (|opcode) | start | trap;
  always_comb pc_inc = pc_q + AW'(carry_in);

  seq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (do_call),
    .pop_req   (do_ret),
    .push_data (pc_q + AW'(1)),
    .top_data  (stk_top),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  seq_cond_unit #(.NF(NFLAG)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (adv_en),
    .flags_in (alu_flags),
    .sel      (cond_sel),
    .taken    (cond_taken)
  );

  seq_replay #(.CW(AW), .OPW(OPW)) u_replay (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (adv_en),
    .load     (do_rep & (operand != '0)),
    .count_in (operand),
    .capture  (fetch & (opcode != OPC_REP)),
    .op_in    (opcode),
    .busy     (rep_busy),
    .last     (rep_last),
    .op_out   (rep_op)
  );

  always_comb begin
    pc_d = pc_q;
    if (adv_en) begin
      if (rep_busy) begin
        if (rep_last) pc_d = pc_q + AW'(1);
      end else begin
        unique case (opcode)
          OPC_JMP:  pc_d = operand;
          OPC_CJMP: pc_d = cond_taken ? operand : pc_q + AW'(1);
          OPC_CALL: pc_d = stk_full ? pc_q + AW'(1) : operand;
          OPC_RET:  pc_d = stk_empty ? pc_q + AW'(1) : stk_top;
          OPC_REP:  pc_d = (operand == '0) ? pc_q + AW'(1) : pc_q;
          default:  pc_d = pc_inc;
        endcase
      end
    end
  end

  always_comb begin
    err_d = err_q | (do_call & stk_full) | (do_ret & stk_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    if (rep_busy)               issue_op = rep_op;
    else if (opcode == OPC_REP) issue_op = '0;
    else                        issue_op = opcode;
  end

  assign reg_clear = adv_en & (issue_op == OPC_CLR);
  assign pc        = pc_q;
  assign stack_err = err_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_en,
  input logic [4:0]    opcode,
  input logic [AW-1:0] operand,
  input logic          start,
  input logic          trap,
  input logic [AW-1:0] pc,
  input logic          reg_clear,
  input logic          stack_err,
  input logic          rep_busy,
  input logic          rep_last
);
  a_r2_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(pc));

  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !rep_busy && opcode == 5'b00000 && !start && !trap) |=> $stable(pc));

  a_r4_wake_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !rep_busy && opcode == 5'b00000 && (start || trap))
      |=> pc == $past(pc) + AW'(1));

  a_r5_jump_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !rep_busy && opcode == 5'b10011) |=> pc == $past(operand));

  a_r7_clear_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clear |-> adv_en);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  a_r10_replay_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && rep_busy && !rep_last) |=> $stable(pc));
endmodule

bind instr_sequencer seq_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adv_en    (adv_en),
  .opcode    (opcode),
  .operand   (operand),
  .start     (start),
  .trap      (trap),
  .pc        (pc),
  .reg_clear (reg_clear),
  .stack_err (stack_err),
  .rep_busy  (rep_busy),
  .rep_last  (rep_last)
);

// File: tb/instr_sequencer_test.sv
`timescale 1ns/1ps
module instr_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       adv_en;
  logic [4:0] opcode;
  logic [7:0] operand;
  logic [1:0] cond_sel;
  logic [3:0] alu_flags;
  logic       start, trap;
  logic [7:0] pc;
  logic [4:0] issue_op;
  logic       reg_clear, stack_err;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  instr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .opcode(opcode),
    .operand(operand), .cond_sel(cond_sel), .alu_flags(alu_flags),
    .start(start), .trap(trap), .pc(pc), .issue_op(issue_op),
    .reg_clear(reg_clear), .stack_err(stack_err)
  );

  typedef struct packed {
    logic [4:0] op;
    logic [7:0] opd;
    logic [1:0] cs;
    logic [3:0] fl;
    logic       st;
    logic       tr;
    logic [7:0] exp_pc;
    logic       exp_clr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{5'h01, 8'h00, 2'd0, 4'b0001, 1'b0, 1'b0, 8'h01, 1'b0}, // R3
    '{5'h12, 8'h20, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h20, 1'b0}, // R6 zero taken
    '{5'h12, 8'h30, 2'd0, 4'b0010, 1'b0, 1'b0, 8'h21, 1'b0}, // R6 zero not taken
    '{5'h12, 8'h40, 2'd1, 4'b0100, 1'b0, 1'b0, 8'h40, 1'b0}, // R6 carry taken
    '{5'h12, 8'h50, 2'd2, 4'b1000, 1'b0, 1'b0, 8'h50, 1'b0}, // R6 sign taken
    '{5'h12, 8'h60, 2'd3, 4'b0000, 1'b0, 1'b0, 8'h60, 1'b0}, // R6 overflow taken
    '{5'h12, 8'h70, 2'd1, 4'b0000, 1'b0, 1'b0, 8'h61, 1'b0}, // R6 carry not taken
    '{5'h14, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h62, 1'b1}, // R7
    '{5'h13, 8'h10, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h10, 1'b0}, // R5
    '{5'h00, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h10, 1'b0}, // R4 halt
    '{5'h00, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b1, 8'h11, 1'b0}, // R4 trap
    '{5'h00, 8'h00, 2'd0, 4'b0000, 1'b1, 1'b0, 8'h12, 1'b0}, // R4 start
    '{5'h08, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h13, 1'b0}, // R3
    '{5'h15, 8'h80, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h80, 1'b0}, // R8 call
    '{5'h15, 8'h90, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h90, 1'b0}, // R8 nested call
    '{5'h16, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h81, 1'b0}, // R8 return
    '{5'h16, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h14, 1'b0}, // R8 return
    '{5'h0F, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 8'h15, 1'b0}  // R3
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic [7:0] opd,
                       input logic [1:0] cs, input logic [3:0] fl,
                       input logic st, input logic tr, input logic en);
    opcode = op; operand = opd; cond_sel = cs; alu_flags = fl;
    start = st; trap = tr; adv_en = en;
  endtask

  // drive at a falling edge, check combinational outputs, then the address after the rising edge
  task automatic step(input string req, input logic [4:0] op, input logic [7:0] opd,
                      input logic en, input int exp_issue, input int exp_clr,
                      input int exp_pc);
    drive(op, opd, 2'd0, 4'b0000, 1'b0, 1'b0, en);
    #1;
    chk({req, " issue_op"}, issue_op, exp_issue);
    chk({req, " reg_clear"}, reg_clear, exp_clr);
    @(negedge clk);
    chk({req, " pc"}, pc, exp_pc);
  endtask

  task automatic do_reset();
    drive(5'h00, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pc", pc, 0);
    chk("R1 stack_err", stack_err, 0);
    chk("R1 reg_clear", reg_clear, 0);

    // R2 disabled step: jump and clear opcodes present but no enable
    drive(5'h13, 8'h55, 2'd0, 4'b1111, 1'b0, 1'b0, 1'b0);
    #1 chk("R2 reg_clear", reg_clear, 0);
    @(negedge clk);
    chk("R2 pc", pc, 0);
    drive(5'h14, 8'h00, 2'd0, 4'b0000, 1'b0, 1'b0, 1'b0);
    #1 chk("R2 reg_clear clr", reg_clear, 0);
    @(negedge clk);
    chk("R2 pc clr", pc, 0);

    // vector table walk (R3..R8)
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].opd, VECS[i].cs, VECS[i].fl,
            VECS[i].st, VECS[i].tr, 1'b1);
      #1;
      chk($sformatf("R3 vec%0d issue_op", i), issue_op,
          (VECS[i].op == 5'h17) ? 0 : int'(VECS[i].op));
      chk($sformatf("R7 vec%0d reg_clear", i), reg_clear, VECS[i].exp_clr);
      @(negedge clk);
      chk($sformatf("R6 vec%0d pc", i), pc, VECS[i].exp_pc);
    end

    // R10 replay of the last op (0x0F) three times, fetched jump ignored
    step("R10 rep load", 5'h17, 8'd3, 1'b1, 0, 0, 8'h15);
    step("R10 replay1", 5'h13, 8'hAA, 1'b1, 5'h0F, 0, 8'h15);
    step("R10 replay2", 5'h13, 8'hAA, 1'b1, 5'h0F, 0, 8'h15);
    step("R10 replay3", 5'h13, 8'hAA, 1'b1, 5'h0F, 0, 8'h16);
    step("R10 zero count", 5'h17, 8'd0, 1'b1, 0, 0, 8'h17);
    step("R7 clear", 5'h14, 8'h00, 1'b1, 5'h14, 1, 8'h18);
    step("R10 rep one", 5'h17, 8'd1, 1'b1, 0, 0, 8'h18);
    step("R7 replayed clear", 5'h01, 8'h00, 1'b1, 5'h14, 1, 8'h19);
    step("R3 after replay", 5'h01, 8'h00, 1'b1, 5'h01, 0, 8'h1A);

    // R9 underflow, then stickiness
    do_reset();
    step("R9 underflow", 5'h16, 8'h00, 1'b1, 5'h16, 0, 8'h01);
    chk("R9 err after underflow", stack_err, 1);
    step("R9 sticky", 5'h01, 8'h00, 1'b1, 5'h01, 0, 8'h02);
    chk("R9 err still set", stack_err, 1);

    // R8/R9 fill all 8 entries, overflow, then unwind in LIFO order
    do_reset();
    for (int k = 0; k < 8; k++) begin
      step("R8 fill", 5'h15, 8'((k + 1) * 16), 1'b1, 5'h15, 0, (k + 1) * 16);
    end
    chk("R8 no err when full", stack_err, 0);
    step("R9 overflow", 5'h15, 8'hF0, 1'b1, 5'h15, 0, 8'h81);
    chk("R9 err after overflow", stack_err, 1);
    for (int k = 7; k >= 0; k--) begin
      step("R8 unwind", 5'h16, 8'h00, 1'b1, 5'h16, 0, k * 16 + 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule